// File: doc/BRIEF.md
# Binary Tree Bus Station with Branch Masking

This block is one node of a narrow, low-latency tree bus that carries short control messages beside a packet network. Each node has a parent side and two child sides, and a child is either another node or an end module. Requests from the children are merged and passed up. The grant that comes back down is handed to one child, picked in round-robin order when both children compete. While a child holds the grant, its words are registered and passed up toward the root, one tree level per clock.

Words that the root sends back travel down the tree. The first word of a transaction that arrives from above is the address word. It is a bit-vector with one bit per destination module. Each child port covers a fixed, parameterised range of module bits. The node enables a branch when any destination bit falls in that branch's range. Only enabled branches see the address word and the words that follow it, so a disabled branch sees no toggling. A unicast uses one path, a multicast uses several, and a broadcast (all bits set) uses every branch. A word flagged as end-of-transaction closes the transaction and clears the branch enables. The acknowledgement sent to the parent is the AND of the acknowledgements from enabled branches, and a disabled branch counts as having acknowledged.

Top module: `tree_bus_station`

## Requirements
- R1: In the cycle after a synchronous reset, every output is 0.
- R2: `p_req_o` equals the OR of `c_req_i` as sampled at the previous clock edge.
- R3: When no child holds the grant and `p_gnt_i` is high while at least one child requests, exactly one requesting child is granted one cycle later. Bit 0 of `c_gnt_o` is child 0 and bit 1 is child 1, and at most one bit is ever set.
- R4: Round-robin choice: after reset child 0 is preferred. Once a grant is released, the child that did not hold it becomes preferred. A lone requester wins regardless of preference.
- R5: A grant stays unchanged while `p_gnt_i` stays high. It clears one cycle after `p_gnt_i` is seen low.
- R6: While a child holds the grant, its valid word appears on `p_up_vld_o`/`p_up_data_o` one cycle later. Words from a child that does not hold the grant never reach the parent side.
- R7: The first valid downward word after idle is the address word. Child 0 is enabled iff any of address bits [C0_LO..C0_HI] (default 0..3) is set. Child 1 is enabled iff any of bits [C1_LO..C1_HI] (default 4..7) is set. The address word itself goes out one cycle later only on enabled branches.
- R8: Later words of the same transaction go out, one cycle later, only on enabled branches. A disabled branch keeps its valid bit low and its data lines unchanged.
- R9: A word with `p_dn_eot_i` set is forwarded with `c_dn_eot_o` set on enabled branches and then ends the transaction. The next valid downward word is treated as a new address word.
- R10: `p_ack_o` equals, one cycle later, the AND over both branches of (child ack OR branch disabled) while a transaction is open, and 0 when none is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c_req_i | input | 2 | Bus request from each child |
| c_gnt_o | output | 2 | Bus grant to each child |
| c_up_vld_i | input | 2 | Upward word valid from each child |
| c_up_data_i | input | 2*WORD_W | Upward words, child i at bits [i*WORD_W +: WORD_W] |
| c_up_ack_i | input | 2 | Acknowledge from each child |
| c_dn_vld_o | output | 2 | Downward word valid per child |
| c_dn_data_o | output | 2*WORD_W | Downward words per child |
| c_dn_eot_o | output | 2 | End-of-transaction flag per child |
| p_req_o | output | 1 | Merged request to parent |
| p_gnt_i | input | 1 | Grant from parent |
| p_up_vld_o | output | 1 | Upward word valid to parent |
| p_up_data_o | output | WORD_W | Upward word to parent |
| p_ack_o | output | 1 | Merged acknowledge to parent |
| p_dn_vld_i | input | 1 | Downward word valid from parent |
| p_dn_data_i | input | WORD_W | Downward word from parent |
| p_dn_eot_i | input | 1 | End-of-transaction flag from parent |

## Verification
The assertions assume that the parent drops `p_gnt_i` only between transactions. They also assume that the first downward word after each end-of-transaction word is always an address word and never a stray data word. The stimulus follows this rule: each grant round releases `p_gnt_i` together with the child requests, and each downward transaction is exactly an address word, a data word and an end word, with an idle cycle after it. The sweep covers every address value and several request patterns, so every branch-enable combination and both round-robin orders are exercised.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  localparam int NUM_CHILD = 2;
  localparam int MAX_W = 64;

  // Bit vector with ones on positions lo..hi inclusive
  function automatic logic [MAX_W-1:0] range_bits(input int lo, input int hi);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tbs_arbiter.sv
module tbs_arbiter
  import tbs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHILD-1:0] c_req_i,
  input  logic                 p_gnt_i,
  output logic                 p_req_o,
  output logic [NUM_CHILD-1:0] c_gnt_o,
  output logic                 locked_o,
  output logic                 own_o
);
  logic rr_q;
  logic pick;

  always_comb pick = c_req_i[rr_q] ? rr_q : ~rr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_req_o  <= 1'b0;
      c_gnt_o  <= '0;
      locked_o <= 1'b0;
      own_o    <= 1'b0;
      rr_q     <= 1'b0;
    end else begin
      p_req_o <= |c_req_i;
      if (!locked_o) begin
        if (p_gnt_i && (|c_req_i)) begin
          locked_o <= 1'b1;
          own_o    <= pick;
          c_gnt_o  <= pick ? 2'b10 : 2'b01;
        end
      end else if (!p_gnt_i) begin
        locked_o <= 1'b0;
        c_gnt_o  <= '0;
        rr_q     <= ~own_o;
      end
    end
  end

  AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(c_gnt_o)) else $error("grant not one-hot"); // R3
  AST_GNT_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
    (!locked_o && p_gnt_i && (|c_req_i)) |=> ((c_gnt_o & $past(c_req_i)) != 2'b00))
    else $error("grant to non-requester"); // R3
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked_o && p_gnt_i) |=> $stable(c_gnt_o)) else $error("grant moved"); // R5
  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (locked_o && !p_gnt_i) |=> (c_gnt_o == 2'b00)) else $error("grant kept"); // R5
endmodule

// File: rtl/tbs_upward.sv
module tbs_upward
  import tbs_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          locked_i,
  input  logic                          own_i,
  input  logic [NUM_CHILD-1:0]          c_up_vld_i,
  input  logic [NUM_CHILD*WORD_W-1:0]   c_up_data_i,
  output logic                          p_up_vld_o,
  output logic [WORD_W-1:0]             p_up_data_o
);
  logic             sel_vld;
  logic [WORD_W-1:0] sel_data;

  always_comb begin
    sel_vld  = locked_i & c_up_vld_i[own_i];
    sel_data = c_up_data_i[own_i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_up_vld_o  <= 1'b0;
      p_up_data_o <= '0;
    end else begin
      p_up_vld_o <= sel_vld;
      if (sel_vld) p_up_data_o <= sel_data;
    end
  end

  AST_UP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !locked_i |=> !p_up_vld_o) else $error("word passed without grant"); // R6
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel_vld |=> $stable(p_up_data_o)) else $error("idle up data toggled"); // R6
endmodule

// File: rtl/tbs_downward.sv
module tbs_downward
  import tbs_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int C0_LO  = 0,
  parameter int C0_HI  = 3,
  parameter int C1_LO  = 4,
  parameter int C1_HI  = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        p_dn_vld_i,
  input  logic [WORD_W-1:0]           p_dn_data_i,
  input  logic                        p_dn_eot_i,
  input  logic [NUM_CHILD-1:0]        c_up_ack_i,
  output logic [NUM_CHILD-1:0]        c_dn_vld_o,
  output logic [NUM_CHILD*WORD_W-1:0] c_dn_data_o,
  output logic [NUM_CHILD-1:0]        c_dn_eot_o,
  output logic                        p_ack_o
);
  localparam logic [WORD_W-1:0] RANGE0 = WORD_W'(range_bits(C0_LO, C0_HI));
  localparam logic [WORD_W-1:0] RANGE1 = WORD_W'(range_bits(C1_LO, C1_HI));

  logic                 active_q;
  logic [NUM_CHILD-1:0] mask_q;
  logic [NUM_CHILD-1:0] addr_mask;
  logic [NUM_CHILD-1:0] cur_mask;

  always_comb begin
    addr_mask[0] = |(p_dn_data_i & RANGE0);
    addr_mask[1] = |(p_dn_data_i & RANGE1);
    cur_mask     = (p_dn_vld_i && !active_q) ? addr_mask : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mask_q   <= '0;
      p_ack_o  <= 1'b0;
    end else begin
      p_ack_o <= active_q & (&(c_up_ack_i | ~mask_q));
      if (p_dn_vld_i) begin
        if (p_dn_eot_i) begin
          active_q <= 1'b0;
          mask_q   <= '0;
        end else begin
          active_q <= 1'b1;
          mask_q   <= cur_mask;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_CHILD; g++) begin : g_branch
    always_ff @(posedge clk) begin
      if (rst) begin
        c_dn_vld_o[g]               <= 1'b0;
        c_dn_eot_o[g]               <= 1'b0;
        c_dn_data_o[g*WORD_W +: WORD_W] <= '0;
      end else begin
        c_dn_vld_o[g] <= p_dn_vld_i & cur_mask[g];
        c_dn_eot_o[g] <= p_dn_vld_i & cur_mask[g] & p_dn_eot_i;
        if (p_dn_vld_i && cur_mask[g]) c_dn_data_o[g*WORD_W +: WORD_W] <= p_dn_data_i;
      end
    end

    AST_DN_MASKED: assert property (@(posedge clk) disable iff (rst)
      (active_q && p_dn_vld_i && !mask_q[g]) |=>
        (!c_dn_vld_o[g] && $stable(c_dn_data_o[g*WORD_W +: WORD_W])))
      else $error("disabled branch toggled"); // R8
  end

  AST_EOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (p_dn_vld_i && p_dn_eot_i) |=> (!active_q && mask_q == '0))
    else $error("end word left masks set"); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> !p_ack_o) else $error("ack outside transaction"); // R10
endmodule

// File: rtl/tree_bus_station.sv
module tree_bus_station
  import tbs_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int C0_LO  = 0,
  parameter int C0_HI  = 3,
  parameter int C1_LO  = 4,
  parameter int C1_HI  = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              c_req_i,
  output logic [1:0]              c_gnt_o,
  input  logic [1:0]              c_up_vld_i,
  input  logic [2*WORD_W-1:0]     c_up_data_i,
  input  logic [1:0]              c_up_ack_i,
  output logic [1:0]              c_dn_vld_o,
  output logic [2*WORD_W-1:0]     c_dn_data_o,
  output logic [1:0]              c_dn_eot_o,
  output logic                    p_req_o,
  input  logic                    p_gnt_i,
  output logic                    p_up_vld_o,
  output logic [WORD_W-1:0]       p_up_data_o,
  output logic                    p_ack_o,
  input  logic                    p_dn_vld_i,
  input  logic [WORD_W-1:0]       p_dn_data_i,
  input  logic                    p_dn_eot_i
);
  logic locked;
  logic own;

  tbs_arbiter u_arb (
    .clk      (clk),
    .rst      (rst),
    .c_req_i  (c_req_i),
    .p_gnt_i  (p_gnt_i),
    .p_req_o  (p_req_o),
    .c_gnt_o  (c_gnt_o),
    .locked_o (locked),
    .own_o    (own)
  );

  tbs_upward #(.WORD_W(WORD_W)) u_up (
    .clk         (clk),
    .rst         (rst),
    .locked_i    (locked),
    .own_i       (own),
    .c_up_vld_i  (c_up_vld_i),
    .c_up_data_i (c_up_data_i),
    .p_up_vld_o  (p_up_vld_o),
    .p_up_data_o (p_up_data_o)
  );

  tbs_downward #(
    .WORD_W(WORD_W), .C0_LO(C0_LO), .C0_HI(C0_HI), .C1_LO(C1_LO), .C1_HI(C1_HI)
  ) u_dn (
    .clk         (clk),
    .rst         (rst),
    .p_dn_vld_i  (p_dn_vld_i),
    .p_dn_data_i (p_dn_data_i),
    .p_dn_eot_i  (p_dn_eot_i),
    .c_up_ack_i  (c_up_ack_i),
    .c_dn_vld_o  (c_dn_vld_o),
    .c_dn_data_o (c_dn_data_o),
    .c_dn_eot_o  (c_dn_eot_o),
    .p_ack_o     (p_ack_o)
  );
endmodule

// File: tb/tree_bus_station_bench.sv
module tree_bus_station_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     c_req_i = '0;
  logic [1:0]     c_gnt_o;
  logic [1:0]     c_up_vld_i = '0;
  logic [2*W-1:0] c_up_data_i = '0;
  logic [1:0]     c_up_ack_i = '0;
  logic [1:0]     c_dn_vld_o;
  logic [2*W-1:0] c_dn_data_o;
  logic [1:0]     c_dn_eot_o;
  logic           p_req_o;
  logic           p_gnt_i = 1'b0;
  logic           p_up_vld_o;
  logic [W-1:0]   p_up_data_o;
  logic           p_ack_o;
  logic           p_dn_vld_i = 1'b0;
  logic [W-1:0]   p_dn_data_i = '0;
  logic           p_dn_eot_i = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  tree_bus_station u_tree_bus_station (
    .clk(clk), .rst(rst),
    .c_req_i(c_req_i), .c_gnt_o(c_gnt_o),
    .c_up_vld_i(c_up_vld_i), .c_up_data_i(c_up_data_i), .c_up_ack_i(c_up_ack_i),
    .c_dn_vld_o(c_dn_vld_o), .c_dn_data_o(c_dn_data_o), .c_dn_eot_o(c_dn_eot_o),
    .p_req_o(p_req_o), .p_gnt_i(p_gnt_i),
    .p_up_vld_o(p_up_vld_o), .p_up_data_o(p_up_data_o), .p_ack_o(p_ack_o),
    .p_dn_vld_i(p_dn_vld_i), .p_dn_data_i(p_dn_data_i), .p_dn_eot_i(p_dn_eot_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic       rr_m;
    logic       pick;
    logic [1:0] pats [8];
    logic [W-1:0] exp_d [2];
    pats = '{2'b11, 2'b11, 2'b01, 2'b11, 2'b10, 2'b00, 2'b11, 2'b11};
    rr_m = 1'b0;
    exp_d[0] = '0;
    exp_d[1] = '0;

    // reset
    c_req_i = 2'b11; c_up_vld_i = 2'b11; p_dn_vld_i = 1'b1; p_gnt_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 gnt", c_gnt_o, 0);
    chk("R1 preq", p_req_o, 0);
    chk("R1 up", {p_up_vld_o, p_up_data_o}, 0);
    chk("R1 dn", {c_dn_vld_o, c_dn_eot_o, c_dn_data_o, p_ack_o}, 0);
    c_req_i = '0; c_up_vld_i = '0; p_dn_vld_i = 1'b0; p_gnt_i = 1'b0;
    rst = 1'b0;

    // R2 request merge sweep, no grant
    for (int r = 0; r < 4; r++) begin
      c_req_i = r[1:0];
      @(negedge clk);
      chk("R2 preq", p_req_o, (r != 0));
      chk("R3 no gnt without parent", c_gnt_o, 0);
    end
    c_req_i = '0;
    @(negedge clk);

    // R6 idle: words without grant never climb
    c_up_vld_i = 2'b11; c_up_data_i = 16'h5A3C;
    @(negedge clk);
    chk("R6 no grant up vld", p_up_vld_o, 0);
    c_up_vld_i = '0;

    // grant rounds: R3 R4 R5 R6
    for (int k = 0; k < 8; k++) begin
      c_req_i = pats[k];
      p_gnt_i = 1'b1;
      @(negedge clk);
      chk("R2 preq in round", p_req_o, (pats[k] != 0));
      if (pats[k] == 2'b00) begin
        chk("R3 no requester", c_gnt_o, 0);
      end else begin
        pick = pats[k][rr_m] ? rr_m : ~rr_m;
        chk("R4 rr pick", c_gnt_o, pick ? 2'b10 : 2'b01);
        // both children offer words; only the owner's climbs
        c_up_vld_i = 2'b11;
        c_up_data_i = {8'h10 + 8'(k), 8'h80 + 8'(k)};
        @(negedge clk);
        chk("R6 up vld", p_up_vld_o, 1);
        chk("R6 up data", p_up_data_o, pick ? (8'h10 + 8'(k)) : (8'h80 + 8'(k)));
        chk("R5 gnt held", c_gnt_o, pick ? 2'b10 : 2'b01);
        // only the non-owner offers a word
        c_up_vld_i = pick ? 2'b01 : 2'b10;
        c_up_data_i = 16'hFFFF;
        @(negedge clk);
        chk("R6 non-owner blocked", p_up_vld_o, 0);
        chk("R6 data held", p_up_data_o, pick ? (8'h10 + 8'(k)) : (8'h80 + 8'(k)));
        c_up_vld_i = '0;
        rr_m = ~pick;
      end
      p_gnt_i = 1'b0;
      c_req_i = '0;
      @(negedge clk);
      chk("R5 release", c_gnt_o, 0);
      @(negedge clk);
    end

    // downward sweep over every address: R7 R8 R9 R10
    for (int a = 0; a < 256; a++) begin
      logic [1:0] m;
      logic [1:0] ak;
      logic [W-1:0] d1;
      logic [W-1:0] d2;
      m  = {|a[7:4], |a[3:0]};
      ak = a[5:4] ^ a[1:0];
      d1 = ~a[7:0];
      d2 = a[7:0] ^ 8'h5A;

      p_dn_vld_i = 1'b1; p_dn_data_i = a[7:0]; p_dn_eot_i = 1'b0;
      @(negedge clk);
      for (int b = 0; b < 2; b++) if (m[b]) exp_d[b] = a[7:0];
      chk("R7 addr vld", c_dn_vld_o, m);
      chk("R7 addr data0", c_dn_data_o[7:0], exp_d[0]);
      chk("R7 addr data1", c_dn_data_o[15:8], exp_d[1]);
      chk("R9 no eot on addr", c_dn_eot_o, 0);

      c_up_ack_i = ak;
      p_dn_data_i = d1;
      @(negedge clk);
      for (int b = 0; b < 2; b++) if (m[b]) exp_d[b] = d1;
      chk("R8 data vld", c_dn_vld_o, m);
      chk("R8 data0", c_dn_data_o[7:0], exp_d[0]);
      chk("R8 data1", c_dn_data_o[15:8], exp_d[1]);
      chk("R10 ack", p_ack_o, &(ak | ~m));

      p_dn_data_i = d2; p_dn_eot_i = 1'b1;
      @(negedge clk);
      for (int b = 0; b < 2; b++) if (m[b]) exp_d[b] = d2;
      chk("R9 eot vld", c_dn_vld_o, m);
      chk("R9 eot flag", c_dn_eot_o, m);
      chk("R8 eot data0", c_dn_data_o[7:0], exp_d[0]);
      chk("R8 eot data1", c_dn_data_o[15:8], exp_d[1]);
      chk("R10 ack open", p_ack_o, &(ak | ~m));

      p_dn_vld_i = 1'b0; p_dn_eot_i = 1'b0;
      @(negedge clk);
      chk("R9 closed vld", c_dn_vld_o, 0);
      chk("R10 ack closed", p_ack_o, 0);
      chk("R8 idle hold", c_dn_data_o, {exp_d[1], exp_d[0]});
      c_up_ack_i = '0;
    end

    summary();
  end
endmodule